// File: doc/BRIEF.md
# Programmable Lookup-Table Logic Cell

This block is one tile of a lookup-table logic fabric. Two 3-input lookup tables take their own input triples. Their outputs feed a full adder that also takes an external carry input. A selector driven by a live data pin, `route_sel`, picks one of the two table outputs. A stored configuration bit chooses whether that pick or the adder sum reaches the data output. A second stored bit chooses between that combinational value and a copy of the selector output registered on `clk`. The adder's carry always leaves on its own pin.

Every truth table and select bit lives in a volatile 18-bit shift chain. The chain is loaded serially on `cfg_clk` while `cfg_en` is high. `cfg_done` reports that a full image has arrived. Until the cell is live, both the data output and the carry output stay at 0. A reset erases the configuration, so the image must be shifted in again after every reset.

Top module: `lut_cell`

## Requirements
- R1: A lookup table's output equals bit `{in[2],in[1],in[0]}` of its 8-bit truth table. Bit 0 is the result for all-zero inputs.
- R2: `carry_out` is the carry of adding the two table outputs and `carry_in`. It is the majority of the three values.
- R3: The live selector passes table 0's output when `route_sel` is 0 and table 1's output when it is 1. With both stored select bits at 0, this value appears on `data_out`.
- R4: When the sum-select bit is 1 and the register-select bit is 0, `data_out` is the XOR of both table outputs and `carry_in`. With two pass-through tables (truth table 8'hAA each), the cell acts as a plain full adder of `lut0_in[0]`, `lut1_in[0]` and `carry_in`.
- R5: When the register-select bit is 1, `data_out` shows a flip-flop that captures the live selector's output on each rising `clk` edge once the cell is live. Input changes between edges do not reach `data_out`.
- R6: The image is 18 bits wide and is shifted in most significant bit first, one bit per rising `cfg_clk` edge while `cfg_en` is 1. The bit layout is: bits 17..10 hold table 0, bits 9..2 hold table 1, bit 1 is the sum-select and bit 0 is the register-select.
- R7: While `cfg_en` is 0, `cfg_din` has no effect and the loaded function is unchanged.
- R8: `cfg_done` is 0 after reset and stays 0 until 18 bits have been shifted. It then stays 1 until the next reset.
- R9: While `cfg_done` is 0, `data_out` and `carry_out` are 0. After it rises, both outputs follow the configured function within three rising `clk` edges.
- R10: Asserting `rst_n` low clears the configuration, `cfg_done` and the flip-flop at once. The outputs stay 0 after release until a new image is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered path |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| cfg_done | output | 1 | High once a full image is loaded |
| lut0_in | input | 3 | Inputs of table 0, `{in2,in1,in0}` |
| lut1_in | input | 3 | Inputs of table 1, `{in2,in1,in0}` |
| carry_in | input | 1 | Adder carry input |
| route_sel | input | 1 | Live select between the two table outputs |
| data_out | output | 1 | Cell data output |
| carry_out | output | 1 | Adder carry output |

## Verification
The adder image is swept over all eight operand and carry triples with both `route_sel` values. This separates the sum from the carry, and shows that the live selector is bypassed. An asymmetric truth table on table 0 and a majority table on table 1 are read out over all eight inputs through both selector positions. This exposes any swap in input bit order, table placement in the chain or select polarity. The registered image is driven with inputs that change between clock edges, which separates the flip-flop from the combinational path. A partial load, a stretch of toggling data with the enable low, and a mid-run reset show the gating and hold behaviour.

// File: rtl/cell_pkg.sv
package cell_pkg;
  localparam int unsigned LUT_K_DEF = 3;
  localparam int unsigned NUM_LUTS  = 2;
  localparam int unsigned SEL_BITS  = 2;
  // positions of the two select bits at the tail of the image
  localparam int unsigned SUM_SEL_POS = 1;
  localparam int unsigned REG_SEL_POS = 0;

  typedef enum logic {SRC_ROUTE = 1'b0, SRC_SUM = 1'b1} comb_src_e;
  typedef enum logic {PATH_COMB = 1'b0, PATH_REG = 1'b1} out_path_e;
endpackage

// File: rtl/sync_bit.sv
module sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             cfg_clk,
  input  logic             srst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic [WIDTH-1:0] cfg_word,
  output logic             cfg_done
);
  localparam int unsigned CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);

  logic [WIDTH-1:0] word_q, word_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (cfg_en) begin
      word_d = {word_q[WIDTH-2:0], cfg_din};
      if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge cfg_clk or negedge srst_n) begin
    if (!srst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cfg_word = word_q;
  assign cfg_done = (cnt_q == CNT_FULL);
endmodule

// File: rtl/lut_k.sv
module lut_k #(
  parameter int unsigned K = 3
) (
  input  logic [(1<<K)-1:0] truth,
  input  logic [K-1:0]      idx,
  output logic              y
);
  assign y = truth[idx];
endmodule

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int unsigned LUT_K       = cell_pkg::LUT_K_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clk,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic             cfg_done,
  input  logic [LUT_K-1:0] lut0_in,
  input  logic [LUT_K-1:0] lut1_in,
  input  logic             carry_in,
  input  logic             route_sel,
  output logic             data_out,
  output logic             carry_out
);
  import cell_pkg::*;

  localparam int unsigned TBL_W = 1 << LUT_K;
  localparam int unsigned CFG_W = NUM_LUTS * TBL_W + SEL_BITS;

  logic             cfg_srst_n;
  logic             clk_srst_n;
  logic [CFG_W-1:0] cfg_word;
  logic             cell_live;
  logic [NUM_LUTS-1:0]            lut_y;
  logic [NUM_LUTS-1:0][LUT_K-1:0] lut_idx;
  logic             sum;
  logic             cout;
  logic             first_mux;
  logic             comb_val;
  logic             reg_q, reg_d;
  comb_src_e        comb_src;
  out_path_e        out_path;

  // reset release aligned to each clock domain
  sync_bit #(.STAGES(SYNC_STAGES)) u_rsync_cfg (
    .clk(cfg_clk), .clr_n(rst_n), .d(1'b1), .q(cfg_srst_n));
  sync_bit #(.STAGES(SYNC_STAGES)) u_rsync_clk (
    .clk(clk), .clr_n(rst_n), .d(1'b1), .q(clk_srst_n));

  cfg_chain #(.WIDTH(CFG_W)) u_chain (
    .cfg_clk (cfg_clk),
    .srst_n  (cfg_srst_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .cfg_word(cfg_word),
    .cfg_done(cfg_done)
  );

  // loaded flag carried into the clk domain
  sync_bit #(.STAGES(SYNC_STAGES)) u_live_sync (
    .clk(clk), .clr_n(clk_srst_n), .d(cfg_done), .q(cell_live));

  assign lut_idx[0] = lut0_in;
  assign lut_idx[1] = lut1_in;

  for (genvar g = 0; g < NUM_LUTS; g++) begin : g_lut
    lut_k #(.K(LUT_K)) u_lut (
      .truth(cfg_word[CFG_W-1-g*TBL_W -: TBL_W]),
      .idx  (lut_idx[g]),
      .y    (lut_y[g])
    );
  end

  assign comb_src = comb_src_e'(cfg_word[SUM_SEL_POS]);
  assign out_path = out_path_e'(cfg_word[REG_SEL_POS]);

  always_comb begin
    sum       = lut_y[0] ^ lut_y[1] ^ carry_in;
    cout      = (lut_y[0] & lut_y[1]) | (carry_in & (lut_y[0] ^ lut_y[1]));
    first_mux = route_sel ? lut_y[1] : lut_y[0];
    comb_val  = (comb_src == SRC_SUM) ? sum : first_mux;
  end

  // registered path: enabled once the cell is live
  always_comb begin
    reg_d = reg_q;
    if (cell_live) reg_d = first_mux;
  end

  always_ff @(posedge clk or negedge clk_srst_n) begin
    if (!clk_srst_n) reg_q <= 1'b0;
    else             reg_q <= reg_d;
  end

  always_comb begin
    data_out  = 1'b0;
    carry_out = 1'b0;
    if (cell_live) begin
      data_out  = (out_path == PATH_REG) ? reg_q : comb_val;
      carry_out = cout;
    end
  end
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
  parameter int unsigned LUT_K = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_clk,
  input logic                          cfg_en,
  input logic                          cfg_done,
  input logic [2*(1<<LUT_K)+1:0]       cfg_word,
  input logic                          cell_live,
  input logic [1:0]                    lut_y,
  input logic                          carry_in,
  input logic                          first_mux,
  input logic                          reg_q,
  input logic                          data_out,
  input logic                          carry_out
);
  a_r8_done_sticks: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  a_r8_done_from_shift: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(cfg_en));

  a_r7_chain_holds: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_word));

  a_r9_quiet_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (data_out == 1'b0 && carry_out == 1'b0));

  a_r2_carry_majority: assert property (@(posedge clk) disable iff (!rst_n)
    cell_live |-> carry_out == ((lut_y[0] & lut_y[1]) | (lut_y[0] & carry_in) | (lut_y[1] & carry_in)));

  a_r4_sum_output: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_live && cfg_word[1] && !cfg_word[0]) |-> data_out == (lut_y[0] ^ lut_y[1] ^ carry_in));

  a_r5_reg_captures: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cell_live) |-> reg_q == $past(first_mux));
endmodule

bind lut_cell lut_cell_chk #(.LUT_K(LUT_K)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_clk  (cfg_clk),
  .cfg_en   (cfg_en),
  .cfg_done (cfg_done),
  .cfg_word (cfg_word),
  .cell_live(cell_live),
  .lut_y    (lut_y),
  .carry_in (carry_in),
  .first_mux(first_mux),
  .reg_q    (reg_q),
  .data_out (data_out),
  .carry_out(carry_out)
);

// File: tb/lut_cell_bench.sv
`timescale 1ns/1ps
module lut_cell_bench;
  localparam int CFG_W = 18;

  logic clk = 1'b0;
  logic cfg_clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic cfg_done;
  logic [2:0] lut0_in = '0;
  logic [2:0] lut1_in = '0;
  logic carry_in = 1'b0;
  logic route_sel = 1'b0;
  logic data_out;
  logic carry_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;       // 50 MHz
  always #15 cfg_clk = ~cfg_clk;

  lut_cell u_lut_cell (
    .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_en(cfg_en),
    .cfg_din(cfg_din), .cfg_done(cfg_done), .lut0_in(lut0_in),
    .lut1_in(lut1_in), .carry_in(carry_in), .route_sel(route_sel),
    .data_out(data_out), .carry_out(carry_out));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] image(input logic [7:0] t0, input logic [7:0] t1,
                                        input logic sum_sel, input logic reg_sel);
    return {t0, t1, sum_sel, reg_sel};
  endfunction

  function automatic logic maj(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge cfg_clk);
  endtask

  task automatic shift_bits(input logic [17:0] w, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      @(negedge cfg_clk);
      cfg_en = 1'b1;
      cfg_din = w[i];
    end
    @(negedge cfg_clk);
    cfg_en = 1'b0;
  endtask

  task automatic settle_live();
    repeat (4) @(negedge clk);
  endtask

  task automatic load(input logic [17:0] w);
    shift_bits(w, CFG_W-1, 0);
    settle_live();
  endtask

  task automatic drive(input logic [2:0] a, input logic [2:0] b, input logic c, input logic s);
    @(negedge clk);
    lut0_in = a; lut1_in = b; carry_in = c; route_sel = s;
    #2;
  endtask

  // R8 R9: nothing appears before an image is loaded
  task automatic t_reset_state();
    do_reset();
    drive(3'b111, 3'b111, 1'b1, 1'b0);
    check("R8 cfg_done after reset", cfg_done, 1'b0);
    check("R9 data_out before load", data_out, 1'b0);
    check("R9 carry_out before load", carry_out, 1'b0);
  endtask

  // R8 R9: 17 bits leave the cell unloaded, the 18th completes it
  task automatic t_partial();
    logic [17:0] w = image(8'hAA, 8'hAA, 1'b1, 1'b0);
    do_reset();
    shift_bits(w, CFG_W-1, 1);
    drive(3'b001, 3'b001, 1'b1, 1'b0);
    check("R8 cfg_done after 17 bits", cfg_done, 1'b0);
    check("R9 carry_out after 17 bits", carry_out, 1'b0);
    shift_bits(w, 0, 0);
    check("R8 cfg_done after 18 bits", cfg_done, 1'b1);
    settle_live();
    drive(3'b001, 3'b001, 1'b1, 1'b0);
    check("R9 data_out live", data_out, 1'b1);
    check("R9 carry_out live", carry_out, 1'b1);
  endtask

  // R4 R2 R6: pass-through tables make a full adder
  task automatic t_adder();
    do_reset();
    load(image(8'hAA, 8'hAA, 1'b1, 1'b0));
    for (int v = 0; v < 16; v++) begin
      logic a = v[0], b = v[1], c = v[2];
      drive({2'b10, a}, {2'b01, b}, c, v[3]);
      check("R4 adder sum", data_out, a ^ b ^ c);
      check("R2 adder carry", carry_out, maj(a, b, c));
    end
  endtask

  // R1 R3 R6: asymmetric table readout through both selector positions
  task automatic t_function();
    logic [7:0] t0 = 8'h2C;
    logic [7:0] t1 = 8'hE8;
    do_reset();
    load(image(t0, t1, 1'b0, 1'b0));
    for (int v = 0; v < 8; v++) begin
      logic [2:0] i0 = 3'(v);
      logic [2:0] i1 = 3'(7 - v);
      drive(i0, i1, v[0], 1'b0);
      check("R1 R6 table 0 via route_sel=0", data_out, t0[i0]);
      check("R2 carry of tables", carry_out, maj(t0[i0], t1[i1], v[0]));
      drive(i0, i1, v[0], 1'b1);
      check("R3 R6 table 1 via route_sel=1", data_out, t1[i1]);
    end
  endtask

  // R5: registered path follows the selector one edge late
  task automatic t_registered();
    logic exp_q;
    do_reset();
    load(image(8'hAA, 8'h55, 1'b0, 1'b1));
    drive(3'b000, 3'b000, 1'b0, 1'b0);
    @(negedge clk);
    exp_q = 1'b0;
    for (int v = 0; v < 8; v++) begin
      logic a = v[0], b = v[1], s = v[2];
      drive({2'b00, a}, {2'b00, b}, 1'b0, s);
      check("R5 held between edges", data_out, exp_q);
      exp_q = s ? ~b : a;
      @(negedge clk);
      #2;
      check("R5 captured on edge", data_out, exp_q);
    end
  endtask

  // R7: data toggling with the enable low leaves the function alone
  task automatic t_hold();
    do_reset();
    load(image(8'hAA, 8'hAA, 1'b1, 1'b0));
    for (int i = 0; i < 20; i++) begin
      @(negedge cfg_clk);
      cfg_en = 1'b0;
      cfg_din = ~cfg_din;
    end
    settle_live();
    check("R7 cfg_done kept", cfg_done, 1'b1);
    drive(3'b001, 3'b000, 1'b0, 1'b0);
    check("R7 sum kept", data_out, 1'b1);
    drive(3'b001, 3'b001, 1'b1, 1'b0);
    check("R7 sum kept", data_out, 1'b1);
    check("R7 carry kept", carry_out, 1'b1);
  endtask

  // R10: reset wipes the image and outputs stay quiet until reload
  task automatic t_reset_clears();
    do_reset();
    load(image(8'hFF, 8'hFF, 1'b0, 1'b0));
    drive(3'b000, 3'b000, 1'b1, 1'b0);
    check("R10 loaded before reset", data_out, 1'b1);
    rst_n = 1'b0;
    #2;
    check("R10 data_out in reset", data_out, 1'b0);
    check("R10 cfg_done in reset", cfg_done, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle_live();
    drive(3'b000, 3'b000, 1'b1, 1'b0);
    check("R10 data_out after release", data_out, 1'b0);
    check("R10 carry_out after release", carry_out, 1'b0);
    load(image(8'h00, 8'h00, 1'b0, 1'b0));
    drive(3'b111, 3'b111, 1'b1, 1'b1);
    check("R10 new image used", data_out, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_partial();
    t_adder();
    t_function();
    t_registered();
    t_hold();
    t_reset_clears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule